// File: doc/BRIEF.md
# Dual-Mode Unsigned Multiply / Multiply-Accumulate Unit

This block multiplies two 32-bit unsigned operands into a 64-bit result. It also keeps a 64-bit accumulator. A host reaches it through a small bank of mapped registers. Writes use byte-lane strobes, and reads return data on the same cycle. Two 32-bit operand buses feed the multiplier directly.

The block runs in one of two modes, chosen by a mode bit in the control register.

- **Multiply-only mode.** The block takes both operand buses on every clock edge. The product registers then hold the product of the values seen on the previous edge. The accumulator is held at zero.
- **Accumulate mode.** Operands are taken only on a control-register write that sets the mode bit. That write adds the product to the accumulator, and the 64-bit result goes to both the product and accumulator registers. If the addition overflows, a sticky carry flag is set. Writing a one to the carry bit clears the flag and zeroes the accumulator. This clear is applied after any accumulate done by the same write.

No data stream crosses the edge of the block. Every pin is a plain control or data pin with no valid/ready handshake, so there is no back-pressure. A register write completes on the clock edge where `wr_en` is high.

Register map (word addresses):

| Address | Register | Access |
|---|---|---|
| 0 | Control | Bit 0 is the mode (0 = multiply-only, 1 = accumulate). Bit 1 is the carry flag. |
| 1 | Operand A | Read only |
| 2 | Operand B | Read only |
| 3 | Product low | Read only |
| 4 | Product high | Read only |
| 5 | Accumulator low | Read/write |
| 6 | Accumulator high | Read/write |
| 7 | None | Reads as zero |

Top module: `mulacc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero. The unit therefore starts in multiply-only mode with the carry flag clear.
- R2: In multiply-only mode, one edge after the buses carry values a and b, address 3 and address 4 hold the low and high words of the 64-bit unsigned product a*b. Addresses 1 and 2 read back a and b.
- R3: In multiply-only mode, the accumulator (addresses 5 and 6) reads zero. This holds even right after a host write to address 5 or 6.
- R4: A write to address 0 with wr_strb[0]=1 and wr_data[0]=1 does the following:
  - it samples the buses that cycle;
  - it computes the accumulator plus a*b;
  - it loads that 64-bit sum into both the product and the accumulator;
  - it leaves the block in accumulate mode.
- R5: In accumulate mode, when there is no control write, changes on the operand buses alter neither the operand, product nor accumulator registers.
- R6: An accumulate whose 64-bit sum wraps sets the carry flag (address 0, bit 1). The flag stays set through later control writes that carry wr_data[1]=0.
- R7: A control write with wr_strb[0]=1 and wr_data[1]=1 clears the carry flag and zeroes the accumulator. This happens after any accumulate done by the same write, so the product register keeps that write's sum.
- R8: A register write changes only the bytes whose wr_strb bit is set. A control write with wr_strb[0]=0 has no effect: no mode change, no accumulate, no clear.
- R9: Address 7 reads zero. Bits 31:2 of the control register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_strb | input | 4 | Byte-lane strobes for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| opa_in | input | 32 | Operand A bus |
| opb_in | input | 32 | Operand B bus |

## Verification
The bench targets these corner cases:

- **Accumulator wrap.** The bench preloads an all-ones accumulator and adds a small product. A design with a narrow or misplaced carry would leave the flag clear or report a wrong low word.
- **Clear on the same write as an accumulate.** This write must still show its sum in the product register while the accumulator reads zero. A design that clears before accumulating would show the wrong product.
- **Sticky flag.** A later plain accumulate must keep the flag set.
- **Byte lanes.** Partial-lane writes must change only the strobed bytes. A control write without lane 0 must do nothing, so a design that ignores strobes would accumulate or switch mode by mistake.
- **Multiply-only mode.** The bench walks extreme operand pairs, including all-ones times all-ones. A truncating multiplier would lose the high word. A host write to the accumulator in this mode must read back as zero.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_OPA     = 3'd1,
    RA_OPB     = 3'd2,
    RA_PROD_LO = 3'd3,
    RA_PROD_HI = 3'd4,
    RA_ACC_LO  = 3'd5,
    RA_ACC_HI  = 3'd6,
    RA_NONE    = 3'd7
  } reg_addr_e;

  localparam int CTRL_MODE_BIT  = 0;
  localparam int CTRL_CARRY_BIT = 1;
endpackage

// File: rtl/mulacc_lane_merge.sv
module mulacc_lane_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0]   old_word,
  input  logic [W-1:0]   new_word,
  input  logic [W/8-1:0] lanes,
  output logic [W-1:0]   merged
);
  localparam int NLANE = W / 8;

  // One byte-wide mux per lane: the new byte replaces the old one only where its strobe is set.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign merged[g*8 +: 8] = lanes[g] ? new_word[g*8 +: 8] : old_word[g*8 +: 8];
  end
endmodule

// File: rtl/mulacc_arith.sv
module mulacc_arith #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic [2*OP_W-1:0] acc,
  output logic [2*OP_W-1:0] product,
  output logic [2*OP_W-1:0] sum,
  output logic              wrap
);
  localparam int RES_W = 2 * OP_W;

  logic [RES_W:0] full_sum;

  // Zero-extend both operands so the multiply is unsigned and keeps all RES_W bits.
  assign product  = {{OP_W{1'b0}}, opa} * {{OP_W{1'b0}}, opb};
  // One extra bit on the adder catches the carry out of the 64-bit sum.
  assign full_sum = {1'b0, acc} + {1'b0, product};
  assign sum      = full_sum[RES_W-1:0];
  assign wrap     = full_sum[RES_W];

  // R6: a carry out means the truncated sum came out below the old accumulator.
  always_comb begin
    if (wrap == 1'b1) begin
      p_wrap_smaller_r6: assert (sum < acc);
    end
  end
endmodule

// File: rtl/mulacc_readmux.sv
module mulacc_readmux
  import mulacc_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode,
  input  logic              carry,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic [2*OP_W-1:0] prod,
  input  logic [2*OP_W-1:0] acc,
  output logic [OP_W-1:0]   data
);
  logic [OP_W-1:0] ctrl_word;

  // R9: only the mode and carry bits of the control register are ever non-zero.
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_MODE_BIT]  = mode;
    ctrl_word[CTRL_CARRY_BIT] = carry;
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      RA_CTRL:    data = ctrl_word;
      RA_OPA:     data = opa;
      RA_OPB:     data = opb;
      RA_PROD_LO: data = prod[OP_W-1:0];
      RA_PROD_HI: data = prod[2*OP_W-1:OP_W];
      RA_ACC_LO:  data = acc[OP_W-1:0];
      RA_ACC_HI:  data = acc[2*OP_W-1:OP_W];
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [OP_W/8-1:0]   wr_strb,
  input  logic [OP_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [OP_W-1:0]     rd_data,
  input  logic [OP_W-1:0]     opa_in,
  input  logic [OP_W-1:0]     opb_in
);
  localparam int RES_W = 2 * OP_W;

  logic              mode_q, mode_d;
  logic              carry_q, carry_d;
  logic [OP_W-1:0]   opa_q, opa_d, opb_q, opb_d;
  logic [RES_W-1:0]  prod_q, prod_d, acc_q, acc_d;
  logic [RES_W-1:0]  mul_only, mac_sum;
  logic              mac_wrap;
  logic [OP_W-1:0]   alo_merged, ahi_merged;
  logic              ctrl_wr, mac_fire, clear_req, alo_wr, ahi_wr;

  // Decode the register write. Only byte lane 0 of the control register holds live bits.
  assign ctrl_wr   = wr_en && (wr_addr == RA_CTRL) && wr_strb[0];
  assign mac_fire  = ctrl_wr && wr_data[CTRL_MODE_BIT];
  assign clear_req = ctrl_wr && wr_data[CTRL_CARRY_BIT];
  assign alo_wr    = wr_en && (wr_addr == RA_ACC_LO);
  assign ahi_wr    = wr_en && (wr_addr == RA_ACC_HI);

  mulacc_arith #(.OP_W(OP_W)) u_arith (
    .opa     (opa_in),
    .opb     (opb_in),
    .acc     (acc_q),
    .product (mul_only),
    .sum     (mac_sum),
    .wrap    (mac_wrap)
  );

  mulacc_lane_merge #(.W(OP_W)) u_merge_lo (
    .old_word (acc_q[OP_W-1:0]),
    .new_word (wr_data),
    .lanes    (wr_strb),
    .merged   (alo_merged)
  );

  mulacc_lane_merge #(.W(OP_W)) u_merge_hi (
    .old_word (acc_q[RES_W-1:OP_W]),
    .new_word (wr_data),
    .lanes    (wr_strb),
    .merged   (ahi_merged)
  );

  // Next-state logic. The order of the branches is the priority:
  //   1. accumulate on a control write that sets the mode bit;
  //   2. otherwise, in multiply-only mode, track the buses every cycle;
  //   3. otherwise, accept host writes to the accumulator.
  // The carry clear comes last, so it always acts after an accumulate on the same write.
  always_comb begin
    mode_d  = mode_q;
    carry_d = carry_q;
    opa_d   = opa_q;
    opb_d   = opb_q;
    prod_d  = prod_q;
    acc_d   = acc_q;
    if (ctrl_wr) mode_d = wr_data[CTRL_MODE_BIT];
    if (mac_fire) begin
      opa_d   = opa_in;
      opb_d   = opb_in;
      prod_d  = mac_sum;
      acc_d   = mac_sum;
      carry_d = carry_q | mac_wrap;
    end else if (!mode_q) begin
      opa_d  = opa_in;
      opb_d  = opb_in;
      prod_d = mul_only;
      acc_d  = '0;
    end else begin
      if (alo_wr) acc_d[OP_W-1:0]     = alo_merged;
      if (ahi_wr) acc_d[RES_W-1:OP_W] = ahi_merged;
    end
    if (clear_req) begin
      carry_d = 1'b0;
      acc_d   = '0;
    end
  end

  // R1: every register resets to zero, which leaves the unit in multiply-only mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
      opa_q   <= '0;
      opb_q   <= '0;
      prod_q  <= '0;
      acc_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      carry_q <= carry_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      prod_q  <= prod_d;
      acc_q   <= acc_d;
    end
  end

  mulacc_readmux #(.OP_W(OP_W)) u_readmux (
    .addr  (rd_addr),
    .mode  (mode_q),
    .carry (carry_q),
    .opa   (opa_q),
    .opb   (opb_q),
    .prod  (prod_q),
    .acc   (acc_q),
    .data  (rd_data)
  );

  // R2: in multiply-only mode the operand registers follow the buses one edge later.
  p_track_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !mac_fire) |=> (opa_q == $past(opa_in) && opb_q == $past(opb_in)));

  // R3: the accumulator is held at zero while in multiply-only mode.
  p_acc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !mac_fire) |=> (acc_q == '0));

  // R4: an accumulate without a clear leaves the product and accumulator equal.
  p_acc_eq_prod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_fire && !clear_req) |=> (acc_q == prod_q && mode_q));

  // R5: in accumulate mode, a cycle with no write holds the operands and the product.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !wr_en) |=> ($stable(prod_q) && $stable(opa_q) && $stable(opb_q)));

  // R6: the carry flag is sticky until an explicit clear.
  p_carry_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_q && !clear_req) |=> carry_q);

  // R7: a clear leaves the flag low and the accumulator at zero.
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (!carry_q && acc_q == '0));
endmodule

// File: tb/mulacc_unit_bench.sv
`timescale 1ns/1ps
module mulacc_unit_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [3:0]    wr_strb = '0;
  logic [W-1:0]  wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [W-1:0]  opa_in = '0;
  logic [W-1:0]  opb_in = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  mulacc_unit u_mulacc_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .opa_in(opa_in), .opb_in(opb_in)
  );

  // Multiply-only stimulus vectors, {operand A, operand B}.
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'h8000_0000, 32'h0000_0002},
    {32'h0001_0000, 32'h0001_0000},
    {32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic rd64(input logic [2:0] lo, output logic [63:0] v);
    logic [W-1:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] s, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0]  v;
    logic [63:0]   v64;

    // R1: registers read zero while in reset and after it is released.
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset", 64'(v), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); check("R1 ctrl after reset", 64'(v), 64'd0);

    // R2: walk the multiply-only vector table.
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opa_in = VEC[i][63:32];
      opb_in = VEC[i][31:0];
      @(negedge clk);
      rd64(3'd3, v64);
      check("R2 product", v64, 64'(VEC[i][63:32]) * 64'(VEC[i][31:0]));
      rd(3'd1, v); check("R2 opa", 64'(v), 64'(VEC[i][63:32]));
      rd(3'd2, v); check("R2 opb", 64'(v), 64'(VEC[i][31:0]));
      rd64(3'd5, v64); check("R3 acc zero", v64, 64'd0);
    end

    // R4: accumulate steps.
    opa_in = 32'd3; opb_in = 32'd5;
    wr(3'd0, 4'b0001, 32'd1);
    rd64(3'd3, v64); check("R4 prod first", v64, 64'd15);
    rd64(3'd5, v64); check("R4 acc first", v64, 64'd15);
    rd(3'd0, v);     check("R4 mode set", 64'(v), 64'd1);
    opa_in = 32'd2; opb_in = 32'd10;
    wr(3'd0, 4'b0001, 32'd1);
    rd64(3'd5, v64); check("R4 acc second", v64, 64'd35);

    // R5: in accumulate mode, changing buses without a control write changes nothing.
    opa_in = 32'd7; opb_in = 32'd9;
    repeat (3) @(negedge clk);
    rd64(3'd3, v64); check("R5 prod hold", v64, 64'd35);
    rd(3'd1, v);     check("R5 opa hold", 64'(v), 64'd2);
    rd64(3'd5, v64); check("R5 acc hold", v64, 64'd35);

    // R8 and R6: preload an all-ones accumulator, then wrap it.
    wr(3'd5, 4'b1111, 32'hFFFF_FFFF);
    wr(3'd6, 4'b1111, 32'hFFFF_FFFF);
    rd64(3'd5, v64); check("R8 acc preload", v64, 64'hFFFF_FFFF_FFFF_FFFF);
    opa_in = 32'd1; opb_in = 32'd2;
    wr(3'd0, 4'b0001, 32'd1);
    rd64(3'd3, v64); check("R6 wrapped prod", v64, 64'd1);
    rd(3'd0, v);     check("R6 carry set", 64'(v), 64'd3);
    opa_in = 32'd0; opb_in = 32'd0;
    wr(3'd0, 4'b0001, 32'd1);
    rd(3'd0, v);     check("R6 carry sticky", 64'(v), 64'd3);
    rd64(3'd5, v64); check("R6 acc after zero add", v64, 64'd1);

    // R7: clear on the same write as an accumulate.
    opa_in = 32'd4; opb_in = 32'd1;
    wr(3'd0, 4'b0001, 32'd3);
    rd64(3'd3, v64); check("R7 prod keeps sum", v64, 64'd5);
    rd64(3'd5, v64); check("R7 acc zeroed", v64, 64'd0);
    rd(3'd0, v);     check("R7 carry cleared", 64'(v), 64'd1);

    // R8: partial-lane writes, and a control write without lane 0.
    wr(3'd5, 4'b0101, 32'hAABB_CCDD);
    rd64(3'd5, v64); check("R8 lanes", v64, 64'h0000_0000_00BB_00DD);
    opa_in = 32'd6; opb_in = 32'd6;
    wr(3'd0, 4'b1110, 32'd3);
    rd(3'd0, v);     check("R8 ctrl no lane0", 64'(v), 64'd1);
    rd64(3'd5, v64); check("R8 acc untouched", v64, 64'h0000_0000_00BB_00DD);
    rd64(3'd3, v64); check("R8 prod untouched", v64, 64'd5);

    // R3: back to multiply-only mode, where host writes to the accumulator are overridden.
    opa_in = 32'd11; opb_in = 32'd13;
    wr(3'd0, 4'b0001, 32'd0);
    @(negedge clk);
    rd64(3'd5, v64); check("R3 acc cleared", v64, 64'd0);
    rd64(3'd3, v64); check("R2 after mode return", v64, 64'd143);
    wr(3'd5, 4'b1111, 32'h1234_5678);
    rd64(3'd5, v64); check("R3 acc write ignored", v64, 64'd0);

    // R9: the unused address reads zero.
    rd(3'd7, v); check("R9 unused addr", 64'(v), 64'd0);
    rd(3'd0, v); check("R9 ctrl upper bits", 64'(v), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule